// File: doc/BRIEF.md
# Two-Field Vertical Blanking Generator

This block produces the vertical blanking strobe for an interlaced display timing engine. A timing generator supplies the current line count, the current pixel count and the active field. The block compares them against coordinates that software has programmed. Each field has an on point and an off point. Each point is a line number together with a pixel position within that line. The strobe therefore rises and falls at exact pixels, and it can do so at different places in the two fields.

The strobe is separate from any embedded timing codes in the video stream. It works the same way whatever the pixel format is. The four coordinate registers sit behind a small word-wide write/read port. A display enable gates the strobe off and freezes its internal state while the port is idle.

Top module: `vblank_gen`

## Requirements
- R1: There are four coordinate registers. Address 0 is the field 1 start, 1 is the field 1 stop, 2 is the field 2 start and 3 is the field 2 stop. Each register keeps the line number in bits 27:16 and the pixel number in bits 11:0, and reads back exactly what was written to those bits.
- R2: Bits 31:28 and 15:12 of every register always read as zero, and writing ones to them has no effect.
- R3: After reset, all line and pixel fields are 0x000 and `vblank_o` is low.
- R4: Take a clock edge at which the display is enabled, the active field's start line and start pixel both equal the counters, and its stop point does not match. `vblank_o` is high after that edge.
- R5: Take a clock edge at which the display is enabled and the active field's stop line and stop pixel both equal the counters. `vblank_o` is low after that edge.
- R6: When the start point and the stop point of the active field both match on the same edge, the stop wins and `vblank_o` is low afterwards.
- R7: Only the registers of the field selected by `field_i` are compared (0 = field 1, 1 = field 2). A match against the other field's coordinates does not change `vblank_o`.
- R8: If neither point matches, `vblank_o` keeps its value. This includes a cycle where only the line, or only the pixel, of a point matches.
- R9: While `en_i` is low, `vblank_o` is low and the internal blanking state does not change, even on matching coordinates. When `en_i` returns high, the previous state shows again.
- R10: A register write is used by the compare from the clock after the write edge onward. A compare on the same edge as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Display enable |
| field_i | input | 1 | Active field, 0 = field 1, 1 = field 2 |
| line_i | input | 12 | Running frame line count |
| pixel_i | input | 12 | Running frame pixel count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| vblank_o | output | 1 | Vertical blanking strobe |

## Verification
The assertions check the following rules on every cycle:
- the set and clear of the blanking state on a match, with the stop taking priority;
- holding the state when nothing matches;
- freezing the state while disabled;
- storage of the written fields.

Only the bench scenarios can show the rest:
- the address map and the zero reserved bits;
- that the other field's coordinates are ignored;
- the one-edge delay before a written value is used;
- that the state stored during a disable comes back on re-enable.

// File: rtl/vblank_pkg.sv
package vblank_pkg;
  parameter int COORD_W    = 12;
  parameter int DATA_W     = 32;
  parameter int LINE_LSB   = 16;
  parameter int PIX_LSB    = 0;
  parameter int NUM_FIELDS = 2;
  localparam int NUM_REGS  = 2 * NUM_FIELDS;
  localparam int ADDR_W    = $clog2(NUM_REGS);
  localparam int FIELD_W   = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1;

  typedef struct packed {
    logic [COORD_W-1:0] line;
    logic [COORD_W-1:0] pix;
  } coord_t;

  localparam logic [DATA_W-1:0] DATA_MASK =
    ({{(DATA_W-COORD_W){1'b0}}, {COORD_W{1'b1}}} << LINE_LSB) |
    ({{(DATA_W-COORD_W){1'b0}}, {COORD_W{1'b1}}} << PIX_LSB);

  function automatic coord_t word_to_coord(logic [DATA_W-1:0] w);
    coord_t c;
    c.line = w[LINE_LSB +: COORD_W];
    c.pix  = w[PIX_LSB  +: COORD_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] coord_to_word(coord_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[LINE_LSB +: COORD_W] = c.line;
    w[PIX_LSB  +: COORD_W] = c.pix;
    return w;
  endfunction
endpackage

// File: rtl/vblank_regs.sv
module vblank_regs
  import vblank_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  output coord_t [NUM_REGS-1:0]        coord_o
);
  coord_t [NUM_REGS-1:0] regs_q;
  logic unused_wbits;

  assign unused_wbits = ^(wdata_i & ~DATA_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) regs_q <= '0;
    else if (we_i) regs_q[addr_i] <= word_to_coord(wdata_i);
  end

  assign rdata_o = coord_to_word(regs_q[addr_i]);
  assign coord_o = regs_q;

  // R1
  reg_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(addr_i)] == word_to_coord($past(wdata_i)));
endmodule

// File: rtl/vblank_match.sv
module vblank_match
  import vblank_pkg::*;
(
  input  logic [COORD_W-1:0] line_i,
  input  logic [COORD_W-1:0] pixel_i,
  input  coord_t             start_i,
  input  coord_t             stop_i,
  output logic               start_hit_o,
  output logic               stop_hit_o
);
  assign start_hit_o = (line_i == start_i.line) && (pixel_i == start_i.pix);
  assign stop_hit_o  = (line_i == stop_i.line)  && (pixel_i == stop_i.pix);
endmodule

// File: rtl/vblank_gen.sv
module vblank_gen
  import vblank_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [COORD_W-1:0] line_i,
  input  logic [COORD_W-1:0] pixel_i,
  input  logic               reg_we_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               vblank_o
);
  coord_t [NUM_REGS-1:0]   coords;
  logic [NUM_FIELDS-1:0]   start_hit, stop_hit;
  logic                    start_sel, stop_sel;
  logic                    blank_q;

  vblank_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .coord_o (coords)
  );

  // register index = {field, is_stop}
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    vblank_match u_match (
      .line_i      (line_i),
      .pixel_i     (pixel_i),
      .start_i     (coords[2*f]),
      .stop_i      (coords[2*f+1]),
      .start_hit_o (start_hit[f]),
      .stop_hit_o  (stop_hit[f])
    );
  end

  assign start_sel = start_hit[field_i];
  assign stop_sel  = stop_hit[field_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        blank_q <= 1'b0;
    else if (en_i) begin
      if (stop_sel)       blank_q <= 1'b0;
      else if (start_sel) blank_q <= 1'b1;
    end
  end

  assign vblank_o = blank_q & en_i;

  // R4
  start_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && start_sel && !stop_sel) |=> blank_q);
  // R5 R6
  stop_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && stop_sel) |=> !blank_q);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !start_sel && !stop_sel) |=> $stable(blank_q));
  // R9
  disabled_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(blank_q));
endmodule

// File: tb/vblank_gen_bench.sv
module vblank_gen_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [0:0]  field = '0;
  logic [11:0] line = '0;
  logic [11:0] pix = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        vblank;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vblank_gen u_vblank_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .field_i(field),
    .line_i(line), .pixel_i(pix), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .vblank_o(vblank)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  // apply counters for one edge, return sampled at the following negedge
  task automatic step(logic e, logic f, logic [11:0] l, logic [11:0] p);
    @(negedge clk);
    en = e; field = f; line = l; pix = p;
    @(posedge clk);
    @(negedge clk);
    line = 12'hFFE; pix = 12'hFFE;
  endtask

  task automatic t_reset;
    chk("R3 vblank", {31'd0, vblank}, 32'd0);
    for (int i = 0; i < 4; i++) rd_chk("R3 reg", 2'(i), 32'd0);
  endtask

  task automatic t_regs;
    wr(2'd0, 32'hFFFF_FFFF);
    rd_chk("R2 reserved", 2'd0, 32'h0FFF_0FFF);
    wr(2'd3, 32'h0123_0456);
    rd_chk("R1 f2stop", 2'd3, 32'h0123_0456);
    rd_chk("R1 f1start", 2'd0, 32'h0FFF_0FFF);
    wr(2'd1, 32'hF000_F000);
    rd_chk("R2 ignore", 2'd1, 32'h0000_0000);
  endtask

  task automatic t_field2;
    wr(2'd2, {4'd0, 12'd5, 4'd0, 12'd10});
    wr(2'd3, {4'd0, 12'd20, 4'd0, 12'd3});
    step(1, 1, 12'd5, 12'd9);
    chk("R8 line only", {31'd0, vblank}, 0);
    step(1, 1, 12'd4, 12'd10);
    chk("R8 pixel only", {31'd0, vblank}, 0);
    step(1, 1, 12'd5, 12'd10);
    chk("R4 start", {31'd0, vblank}, 1);
    step(1, 1, 12'd6, 12'd10);
    chk("R8 hold", {31'd0, vblank}, 1);
    step(1, 1, 12'd20, 12'd3);
    chk("R5 stop", {31'd0, vblank}, 0);
  endtask

  task automatic t_field_sel;
    wr(2'd0, {4'd0, 12'd7, 4'd0, 12'd7});
    wr(2'd1, {4'd0, 12'd9, 4'd0, 12'd1});
    step(1, 1, 12'd7, 12'd7);
    chk("R7 f1 start under f2", {31'd0, vblank}, 0);
    step(1, 0, 12'd7, 12'd7);
    chk("R4 f1 start", {31'd0, vblank}, 1);
    step(1, 1, 12'd9, 12'd1);
    chk("R7 f1 stop under f2", {31'd0, vblank}, 1);
    step(1, 0, 12'd9, 12'd1);
    chk("R5 f1 stop", {31'd0, vblank}, 0);
  endtask

  task automatic t_prio;
    wr(2'd0, {4'd0, 12'd100, 4'd0, 12'd50});
    wr(2'd1, {4'd0, 12'd100, 4'd0, 12'd50});
    step(1, 0, 12'd100, 12'd50);
    chk("R6 from low", {31'd0, vblank}, 0);
    step(1, 1, 12'd5, 12'd10);
    chk("R4 set", {31'd0, vblank}, 1);
    step(1, 0, 12'd100, 12'd50);
    chk("R6 from high", {31'd0, vblank}, 0);
  endtask

  task automatic t_enable;
    step(1, 1, 12'd5, 12'd10);
    chk("R4 set", {31'd0, vblank}, 1);
    step(0, 1, 12'd0, 12'd0);
    chk("R9 gated", {31'd0, vblank}, 0);
    step(0, 1, 12'd20, 12'd3);
    chk("R9 stop ignored", {31'd0, vblank}, 0);
    step(1, 1, 12'd0, 12'd0);
    chk("R9 state kept", {31'd0, vblank}, 1);
    step(1, 1, 12'd20, 12'd3);
    chk("R5 clear", {31'd0, vblank}, 0);
    step(0, 1, 12'd5, 12'd10);
    step(1, 1, 12'd0, 12'd0);
    chk("R9 start ignored", {31'd0, vblank}, 0);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    en = 1; field = 1; line = 12'd30; pix = 12'd30;
    we = 1; addr = 2'd2; wdata = {4'd0, 12'd30, 4'd0, 12'd30};
    @(posedge clk);
    @(negedge clk);
    we = 0;
    chk("R10 old value", {31'd0, vblank}, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R10 new value", {31'd0, vblank}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_field2();
    t_field_sel();
    t_prio();
    t_enable();
    t_write_timing();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule